// File: doc/BRIEF.md
# Configuration Packet Stream Router

This block sits behind a write-only keyhole window in a configuration path. Software writes 32-bit words into it, and address bits [3:2] choose which of four lanes each word fills. When lane 3 is written, the three stored lanes and the incoming word form one quadword. The block decodes that quadword at once and clears the stored lanes. Decoding can lead to one of three outcomes: a one-cycle packet delivery on one or more row ports, a load of the frame-burst countdown, or nothing.

The block works in two modes. While the burst countdown is nonzero, every committed quadword goes whole to the row that was latched when the countdown was loaded, and the countdown then drops by one. While the countdown is zero, the header in lane 0 decides the outcome. A burst-setup packet loads the countdown. A register packet is sent to a single row, or to every present row when the row field holds the broadcast code. A decompress control input makes the block discard committed quadwords.

All row ports share one register-address bus and one 128-bit data bus. Each row has its own valid bit, and the ports have no backpressure.

Top module: `cfg_pkt_router`

## Requirements
- R1: A write places its data in the lane given by wr_addr[3:2], and the other address bits are ignored. Only a write to lane 3 commits a quadword. Writes to lanes 0 to 2 never produce row output.
- R2: After every commit all stored lanes read as zero, so a lane left unwritten before the next commit contributes zero.
- R3: In lane 0, bits [31:24] hold the packet type, bits [20:16] the row code and bits [13:8] the register address. The other bits have no effect.
- R4: While burst_left is nonzero, a commit drives row_valid one cycle later for the latched row, with row_reg equal to FDATA_REG (default 0x02) and row_data lanes 0 to 3 equal to quadword words 0 to 3 (lane i at bits [32i+31:32i]). burst_left then decreases by one.
- R5: While burst_left is zero, a packet of type UNIT_TYPE (default 0x30) whose register address is FDATA_REG loads burst_left from word 1 and latches the row code. It produces no row output.
- R6: A countdown load whose value is not a multiple of 25 pulses cnt_err for one cycle, and the load still takes place.
- R7: While burst_left is zero, a packet of type FRAME_TYPE (default 0x50) is delivered one cycle after commit with its register address on row_reg, words 1 to 3 in data lanes 0 to 2, and lane 3 zero.
- R8: Row code 0x1F delivers to every row whose bit is set in ROW_PRESENT. Any other valid row code delivers only to that row, and only if the row is present.
- R9: A row code from NROWS up to 30 produces no row output and pulses row_err for one cycle. This applies both to register packets and to bursts aimed at such a latched row, and a burst still decrements the countdown.
- R10: While decomp_en is high, a commit has no effect except clearing the stored lanes. There is no row output and burst_left is unchanged.
- R11: Packets of any other type, and burst-setup packets with any other register address, have no effect.
- R12: A synchronous reset clears the stored lanes, burst_left, the latched row and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the keyhole window |
| wr_addr | input | ADDR_W | Write byte address; bits [3:2] select the lane |
| wr_data | input | 32 | Write data |
| decomp_en | input | 1 | Discard committed quadwords while high |
| burst_left | output | CNT_W | Remaining frame-burst quadwords |
| row_valid | output | NROWS | One-cycle delivery strobe, one bit per row |
| row_reg | output | 6 | Register address of the delivered packet |
| row_data | output | 128 | Four 32-bit data lanes of the delivered packet |
| cnt_err | output | 1 | Pulse: countdown loaded with a non-multiple of 25 |
| row_err | output | 1 | Pulse: packet aimed at a nonexistent row code |

## Verification
The hardest state to reach from the ports is a burst aimed at a row code that does not exist. Reaching it takes a countdown load carrying an out-of-range row, then commits made while the countdown is nonzero. The stimulus also resets the block with a half-filled lane set. A half-filled set must leave no trace. To reach it, the bench writes lane 0, pulses reset, then commits only lanes 1 to 3. All 32 row codes are swept with register packets, and the lane write order is varied. The sweep runs against a present-row mask that has one hole, so broadcast, single-row, absent-row and bad-code outcomes are all compared against masks the bench computes.

// File: rtl/cfg_pkt_router.sv
module cfg_pkt_router #(
  parameter int NROWS = 15,
  parameter int ADDR_W = 12,
  parameter int CNT_W = 32,
  parameter int BURST_MULT = 25,
  parameter logic [7:0] UNIT_TYPE = 8'h30,
  parameter logic [7:0] FRAME_TYPE = 8'h50,
  parameter logic [5:0] FDATA_REG = 6'h02,
  parameter logic [4:0] BCAST_ROW = 5'h1F,
  parameter logic [NROWS-1:0] ROW_PRESENT = {NROWS{1'b1}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              decomp_en,
  output logic [CNT_W-1:0]  burst_left,
  output logic [NROWS-1:0]  row_valid,
  output logic [5:0]        row_reg,
  output logic [127:0]      row_data,
  output logic              cnt_err,
  output logic              row_err
);

  logic [31:0] lane0, lane1, lane2;
  logic [4:0]  held_row;

  wire [1:0]  sel    = wr_addr[3:2];
  wire        commit = wr_en && (sel == 2'd3);
  wire [7:0]  ptype  = lane0[31:24];
  wire [4:0]  prow   = lane0[20:16];
  wire [5:0]  preg   = lane0[13:8];

  wire active    = commit && !decomp_en;
  wire do_burst  = active && (burst_left != '0);
  wire idle      = active && (burst_left == '0);
  wire do_load   = idle && (ptype == UNIT_TYPE) && (preg == FDATA_REG);
  wire do_frame  = idle && (ptype == FRAME_TYPE);
  wire [4:0] tgt = do_burst ? held_row : prow;

  function automatic logic [NROWS-1:0] mask_of(input logic [4:0] r);
    if (r == BCAST_ROW)
      return ROW_PRESENT;
    else if (32'(r) < NROWS)
      return (NROWS'(1) << r) & ROW_PRESENT;
    else
      return '0;
  endfunction

  wire tgt_bad = (tgt != BCAST_ROW) && (32'(tgt) >= NROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane0 <= '0;
      lane1 <= '0;
      lane2 <= '0;
      held_row <= '0;
      burst_left <= '0;
      row_valid <= '0;
      row_reg <= '0;
      row_data <= '0;
      cnt_err <= 1'b0;
      row_err <= 1'b0;
    end else begin
      row_valid <= '0;
      cnt_err <= 1'b0;
      row_err <= 1'b0;
      if (wr_en) begin
        case (sel)
          2'd0: lane0 <= wr_data;
          2'd1: lane1 <= wr_data;
          2'd2: lane2 <= wr_data;
          default: begin
            lane0 <= '0;
            lane1 <= '0;
            lane2 <= '0;
          end
        endcase
      end
      if (do_burst) begin
        row_valid <= mask_of(tgt);
        row_err <= tgt_bad;
        row_reg <= FDATA_REG;
        row_data <= {wr_data, lane2, lane1, lane0};
        burst_left <= burst_left - 1'b1;
      end
      if (do_load) begin
        burst_left <= CNT_W'(lane1);
        held_row <= prow;
        cnt_err <= (lane1 % 32'(BURST_MULT)) != 32'd0;
      end
      if (do_frame) begin
        row_valid <= mask_of(tgt);
        row_err <= tgt_bad;
        row_reg <= preg;
        row_data <= {32'd0, wr_data, lane2, lane1};
      end
    end
  end

  // R1: no commit, no delivery next cycle
  a_r1_quiet_without_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> row_valid == '0);

  // R4: a burst commit consumes exactly one count
  a_r4_burst_decrements: assert property (@(posedge clk) disable iff (rst)
    (commit && !decomp_en && burst_left != '0) |=> burst_left == $past(burst_left) - 1'b1);

  // R10: decompress mode leaves no effect
  a_r10_discard: assert property (@(posedge clk) disable iff (rst)
    (commit && decomp_en) |=> ($stable(burst_left) && row_valid == '0));

  // R8: absent rows never strobe
  a_r8_present_only: assert property (@(posedge clk) disable iff (rst)
    (row_valid & ~ROW_PRESENT) == '0);

  // R9: a bad row code never comes with a delivery
  a_r9_err_silent: assert property (@(posedge clk) disable iff (rst)
    row_err |-> row_valid == '0);

  // R6: error flag only with a non-multiple count
  a_r6_flag_matches_count: assert property (@(posedge clk) disable iff (rst)
    cnt_err |-> (32'(burst_left) % 32'(BURST_MULT)) != 32'd0);

endmodule

// File: tb/sim_cfg_pkt_router.sv
`timescale 1ns/1ps
module sim_cfg_pkt_router;
  localparam int NR = 15;
  localparam logic [NR-1:0] PRES = 15'h7FFB;
  localparam logic [7:0] UT = 8'h30;
  localparam logic [7:0] FT = 8'h50;
  localparam logic [5:0] FD = 6'h02;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic decomp_en = 1'b0;
  logic [31:0] burst_left;
  logic [NR-1:0] row_valid;
  logic [5:0] row_reg;
  logic [127:0] row_data;
  logic cnt_err, row_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cfg_pkt_router #(.ROW_PRESENT(PRES)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .decomp_en(decomp_en), .burst_left(burst_left), .row_valid(row_valid),
    .row_reg(row_reg), .row_data(row_data), .cnt_err(cnt_err), .row_err(row_err));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] emask(input int r);
    if (r == 31) return PRES;
    if (r < NR) return (NR'(1) << r) & PRES;
    return '0;
  endfunction

  task automatic put(input int slot, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 12'(slot * 4) | 12'h350;
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic qw(input logic [31:0] w0, w1, w2, w3, input bit rev);
    if (rev) begin put(2, w2); put(1, w1); put(0, w0); end
    else begin put(0, w0); put(1, w1); put(2, w2); end
    put(3, w3);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] t, input int r, input logic [5:0] g);
    return {t, 3'b101, 5'(r), 2'b11, g, 8'hA5};
  endfunction

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(burst_left == 0 && row_valid == 0 && !cnt_err && !row_err && row_data == 0, "R12 reset state",
        {burst_left, 15'(row_valid)}, 0);

    // R1 partial writes give nothing
    put(0, hdr(FT, 1, 6'h07));
    @(negedge clk); chk(row_valid == 0, "R1 lane0 quiet", row_valid, 0);
    put(1, 32'h11); put(2, 32'h22);
    @(negedge clk); chk(row_valid == 0, "R1 lane2 quiet", row_valid, 0);
    put(3, 32'h33);
    @(negedge clk);
    chk(row_valid == emask(1) && row_reg == 6'h07, "R1 commit on lane3", {row_reg, 15'(row_valid)}, {6'h07, emask(1)});

    // R3 R7 R8 R9 sweep all row codes
    for (int r = 0; r < 32; r++) begin
      logic [31:0] a, b, c;
      logic [5:0] g;
      a = 32'h1000_0000 + 32'(r); b = 32'hB0B0_0000 ^ 32'(r * 7); c = ~a;
      g = 6'(r + 5);
      qw(hdr(FT, r, g), a, b, c, r[0]);
      chk(row_valid == emask(r), "R8 row mask", row_valid, emask(r));
      chk(row_err == (r >= NR && r != 31), "R9 bad row flag", row_err, (r >= NR && r != 31));
      if (emask(r) != 0)
        chk(row_reg == g && row_data == {32'd0, c, b, a}, "R7 R3 packet fields",
            row_data ^ 128'(row_reg), {32'd0, c, b, a} ^ 128'(g));
    end

    // R11 ignored packets
    qw(hdr(UT, 3, 6'h05), 32'd50, 0, 0, 0);
    chk(row_valid == 0 && burst_left == 0, "R11 unit other reg", burst_left, 0);
    qw(hdr(8'h77, 1, FD), 32'd50, 0, 0, 0);
    chk(row_valid == 0 && burst_left == 0, "R11 unknown type", burst_left, 0);

    // R5 load, R4 burst
    qw(hdr(UT, 4, FD), 32'd50, 32'h9, 32'h9, 0);
    chk(burst_left == 50 && row_valid == 0 && !cnt_err, "R5 load", burst_left, 50);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] h;
      h = hdr(FT, 9, 6'h11) + 32'(k);
      qw(h, 32'hA0 + 32'(k), 32'hB0, 32'hC0, k[0]);
      chk(row_valid == emask(4) && row_reg == FD, "R4 burst target", row_valid, emask(4));
      chk(row_data == {32'hC0, 32'hB0, 32'hA0 + 32'(k), h}, "R4 burst data", row_data,
          {32'hC0, 32'hB0, 32'hA0 + 32'(k), h});
      chk(burst_left == 32'(49 - k), "R4 countdown", burst_left, 32'(49 - k));
    end

    // R2 cleared lanes
    put(1, 32'hAAAA); put(3, 32'hBBBB); @(negedge clk);
    chk(row_data == {32'hBBBB, 32'd0, 32'hAAAA, 32'd0} && burst_left == 46, "R2 cleared lanes",
        row_data, {32'hBBBB, 32'd0, 32'hAAAA, 32'd0});

    // R10 decompress discard
    decomp_en = 1'b1;
    qw(32'h5, 32'h6, 32'h7, 32'h8, 0);
    chk(row_valid == 0 && burst_left == 46, "R10 discarded", burst_left, 46);
    decomp_en = 1'b0;
    put(3, 32'hDDDD); @(negedge clk);
    chk(row_data == {32'hDDDD, 96'd0} && burst_left == 45, "R10 lanes cleared", row_data, {32'hDDDD, 96'd0});

    // R12 reset mid-gather
    put(0, hdr(FT, 1, 6'h09));
    do_reset();
    chk(burst_left == 0, "R12 counter cleared", burst_left, 0);
    put(1, 32'h1); put(2, 32'h2); put(3, 32'h3); @(negedge clk);
    chk(row_valid == 0, "R12 lanes cleared", row_valid, 0);

    // R6 R9 burst to bad row
    qw(hdr(UT, 20, FD), 32'd1, 0, 0, 0);
    chk(cnt_err == 1'b1 && burst_left == 1, "R6 flag with load", {cnt_err, burst_left}, {1'b1, 32'd1});
    qw(32'h1, 32'h2, 32'h3, 32'h4, 0);
    chk(row_valid == 0 && row_err && burst_left == 0, "R9 burst bad row", {row_err, burst_left}, {1'b1, 32'd0});

    // R6 R8 broadcast burst
    qw(hdr(UT, 31, FD), 32'd7, 0, 0, 0);
    chk(cnt_err == 1'b1 && burst_left == 7, "R6 load non-multiple", burst_left, 7);
    qw(32'hF0, 32'hF1, 32'hF2, 32'hF3, 1);
    chk(row_valid == PRES && burst_left == 6 && !row_err, "R8 broadcast burst", row_valid, PRES);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule